// File: doc/BRIEF.md
# USB Resume Signalling Detector

This block samples the decoded USB line state once per clock and raises a one-cycle pulse when the line carries a resume request. It is placed beside the suspend logic of a dual-role controller, which supplies a single mode select derived from its own state.

In the default mode, any departure from idle is taken as resume. The strict mode is used while a B-device waits for the A-device to connect, and while an A-device is suspended with the role swap already granted to the B-device. In strict mode only a change from J to K counts as resume. A short SE0 between the J and the K is tolerated. An SE0 that lasts 2.5 µs or longer cancels the attempt. The SE0 length is measured in sample clocks, with the limit derived from the sample clock frequency parameter.

After a pulse, and after any aborted attempt, the detector waits for idle (J) before it can fire again. A single-ended-one state is never treated as resume.

Top module: `usb_resume_detect`

## Requirements
- R1: `line_state` is coded as {D+, D-}: 2'b10 is J (idle), 2'b01 is K, 2'b00 is SE0 and 2'b11 is SE1. After reset the pulse is low and the detector is disarmed. No input produces a pulse until J has been sampled at least once.
- R2: With `strict_mode` low and the detector armed, a sample of K or SE0 drives `resume_pulse` high in the next cycle.
- R3: With `strict_mode` high and the detector armed, a sample of K drives `resume_pulse` high in the next cycle.
- R4: With `strict_mode` high, an SE0 sample never pulses by itself. The sequence J, then n samples of SE0, then K pulses in the cycle after K if and only if n < GAP_LIMIT. GAP_LIMIT = floor(SAMPLE_HZ/1000 × SE0_MAX_NS / 1,000,000), with a minimum of 2.
- R5: In strict mode, the sample at which an SE0 run reaches GAP_LIMIT cancels the attempt. A later K does not pulse until J has been sampled again.
- R6: In strict mode, an SE0 run shorter than GAP_LIMIT that ends in J returns the detector to armed without a pulse.
- R7: A sample of SE1 never produces a pulse and disarms the detector in either mode. J is then needed to arm again.
- R8: `resume_pulse` lasts exactly one cycle. No further pulse occurs until J has been sampled, however long the non-idle state is held.
- R9: `strict_mode` is evaluated on every sample. If it drops during an SE0 gap, the next non-J sample pulses under the default rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_state | input | 2 | Decoded bus state {D+, D-} |
| strict_mode | input | 1 | High selects J-to-K-only qualification |
| resume_pulse | output | 1 | One-cycle resume indication |

## Verification
The bench builds the detector with SAMPLE_HZ = 4,000,000 and SE0_MAX_NS = 2500. This gives a gap limit of just ten samples. The bench can therefore sweep every SE0 gap length from zero to well past the limit, and check the boundary on both sides (nine samples accepted, ten rejected). For every symbol, it also steps through both modes, the armed and disarmed states, the SE1 cases and a change of mode in the middle of a gap.

// File: rtl/resume_det_pkg.sv
package resume_det_pkg;

    // Bus state as {D+, D-}
    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_K   = 2'b01,
        LS_J   = 2'b10,
        LS_SE1 = 2'b11
    } line_e;

    typedef enum logic [1:0] {
        ST_WAIT_IDLE = 2'd0,
        ST_ARMED     = 2'd1,
        ST_GAP       = 2'd2
    } det_state_e;

    typedef struct packed {
        logic is_j;
        logic is_k;
        logic is_se0;
        logic is_se1;
    } line_dec_t;

    typedef struct packed {
        det_state_e state;
        logic       pulse;
    } det_regs_t;

endpackage

// File: rtl/resume_line_decode.sv
module resume_line_decode
    import resume_det_pkg::*;
(
    input  logic [1:0] line_raw,
    output line_dec_t  dec
);

    always_comb begin
        dec        = '0;
        dec.is_j   = (line_raw == LS_J);
        dec.is_k   = (line_raw == LS_K);
        dec.is_se0 = (line_raw == LS_SE0);
        dec.is_se1 = (line_raw == LS_SE1);
    end

endmodule

// File: rtl/resume_gap_timer.sv
module resume_gap_timer #(
    parameter int GAP_LIMIT = 10,
    parameter int CW        = $clog2(GAP_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,      // first SE0 sample of a gap
    input  logic step,      // one more SE0 sample
    output logic at_limit   // next SE0 sample would reach GAP_LIMIT
);

    logic [CW-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (load) begin
            count_d = CW'(1);
        end else if (step && !at_limit) begin
            count_d = count_q + CW'(1);
        end
    end

    assign at_limit = (count_q >= CW'(GAP_LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

endmodule

// File: rtl/usb_resume_detect.sv
module usb_resume_detect
    import resume_det_pkg::*;
#(
    parameter int SAMPLE_HZ  = 48_000_000,
    parameter int SE0_MAX_NS = 2500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] line_state,
    input  logic       strict_mode,
    output logic       resume_pulse
);

    // Samples per 2.5 us window (kHz * ns / 1e6 keeps the product in 32 bits)
    localparam int RAW_LIMIT = ((SAMPLE_HZ / 1000) * SE0_MAX_NS) / 1_000_000;
    localparam int GAP_LIMIT = (RAW_LIMIT < 2) ? 2 : RAW_LIMIT;
    localparam int GAP_CW    = $clog2(GAP_LIMIT + 1);

    line_dec_t dec;
    logic      gap_load, gap_step, gap_at_limit;
    det_regs_t rg_d, rg_q;

    resume_line_decode u_decode (
        .line_raw (line_state),
        .dec      (dec)
    );

    resume_gap_timer #(
        .GAP_LIMIT (GAP_LIMIT),
        .CW        (GAP_CW)
    ) u_gap_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .step     (gap_step),
        .at_limit (gap_at_limit)
    );

    always_comb begin
        rg_d       = rg_q;
        rg_d.pulse = 1'b0;
        gap_load   = 1'b0;
        gap_step   = 1'b0;

        if (dec.is_se1) begin
            // single-ended one: never resume, drop back to idle tracking
            rg_d.state = ST_WAIT_IDLE;
        end else begin
            unique case (rg_q.state)
                ST_WAIT_IDLE: begin
                    if (dec.is_j) rg_d.state = ST_ARMED;
                end
                ST_ARMED: begin
                    if (dec.is_k) begin
                        rg_d.pulse = 1'b1;
                        rg_d.state = ST_WAIT_IDLE;
                    end else if (dec.is_se0) begin
                        if (strict_mode) begin
                            gap_load   = 1'b1;
                            rg_d.state = ST_GAP;
                        end else begin
                            rg_d.pulse = 1'b1;
                            rg_d.state = ST_WAIT_IDLE;
                        end
                    end
                end
                ST_GAP: begin
                    if (dec.is_j) begin
                        rg_d.state = ST_ARMED;
                    end else if (!strict_mode || dec.is_k) begin
                        rg_d.pulse = 1'b1;
                        rg_d.state = ST_WAIT_IDLE;
                    end else if (gap_at_limit) begin
                        rg_d.state = ST_WAIT_IDLE;
                    end else begin
                        gap_step = 1'b1;
                    end
                end
                default: rg_d.state = ST_WAIT_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q.state <= ST_WAIT_IDLE;
            rg_q.pulse <= 1'b0;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign resume_pulse = rg_q.pulse;

endmodule

// File: rtl/usb_resume_detect_chk.sv
module usb_resume_detect_chk #(
    parameter int GAP_LIMIT = 10
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] line_state,
    input logic       strict_mode,
    input logic       resume_pulse
);

    localparam int RW = $clog2(GAP_LIMIT + 1);
    localparam logic [1:0] C_J   = 2'b10;
    localparam logic [1:0] C_K   = 2'b01;
    localparam logic [1:0] C_SE0 = 2'b00;
    localparam logic [1:0] C_SE1 = 2'b11;

    logic [RW-1:0] run_q;
    logic          fired_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q   <= '0;
            fired_q <= 1'b1;
        end else begin
            if (line_state == C_SE0) begin
                if (run_q < RW'(GAP_LIMIT)) run_q <= run_q + RW'(1);
            end else begin
                run_q <= '0;
            end
            if (line_state == C_J)  fired_q <= 1'b0;
            else if (resume_pulse)  fired_q <= 1'b1;
        end
    end

    assert_cause_nonidle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pulse |-> ($past(line_state) != C_J));

    assert_strict_on_k_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_pulse && $past(strict_mode)) |-> ($past(line_state) == C_K));

    assert_gap_short_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_pulse && $past(strict_mode)) |-> ($past(run_q) < RW'(GAP_LIMIT)));

    assert_se1_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(line_state) == C_SE1) |-> !resume_pulse);

    assert_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pulse |=> !resume_pulse);

    assert_rearm_on_j_R8: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pulse |-> !$past(fired_q));

endmodule

bind usb_resume_detect usb_resume_detect_chk #(.GAP_LIMIT(GAP_LIMIT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_state   (line_state),
    .strict_mode  (strict_mode),
    .resume_pulse (resume_pulse)
);

// File: tb/test_usb_resume_detect.sv
`timescale 1ns/1ps
module test_usb_resume_detect;

    localparam int HZ    = 4_000_000;
    localparam int MAXNS = 2500;
    localparam int LIMIT = ((HZ / 1000) * MAXNS) / 1_000_000; // 10 samples

    localparam logic [1:0] J   = 2'b10;
    localparam logic [1:0] K   = 2'b01;
    localparam logic [1:0] SE0 = 2'b00;
    localparam logic [1:0] SE1 = 2'b11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] line = SE0;
    logic       strict = 1'b0;
    logic       pulse;
    int         tests = 0;
    int         fails = 0;

    always #4 clk = ~clk;

    usb_resume_detect #(.SAMPLE_HZ(HZ), .SE0_MAX_NS(MAXNS)) i_usb_resume_detect (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_state   (line),
        .strict_mode  (strict),
        .resume_pulse (pulse)
    );

    task automatic put(input logic [1:0] s);
        @(negedge clk);
        line = s;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic exp);
        tests++;
        if (pulse !== exp) begin
            fails++;
            $display("FAIL %s: resume_pulse=%0b expected %0b", req, pulse, exp);
        end
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog: run did not finish, got 0 expected 1");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: no pulse before first J
        put(K);   check("R1 disarmed K", 1'b0);
        put(SE0); check("R1 disarmed SE0", 1'b0);
        put(K);   check("R1 disarmed K again", 1'b0);

        // R2 / R8: default mode, K and SE0 both resume
        strict = 1'b0;
        for (int s = 0; s < 2; s++) begin
            logic [1:0] sym;
            sym = (s == 0) ? K : SE0;
            put(J);   check("R2 idle", 1'b0);
            put(J);   check("R2 idle", 1'b0);
            put(sym); check("R2 nonidle pulse", 1'b1);
            put(sym); check("R8 single cycle", 1'b0);
            put(sym); check("R8 no repeat", 1'b0);
        end

        // R7: SE1 in default mode
        put(J);   check("R7 idle", 1'b0);
        put(SE1); check("R7 SE1 silent", 1'b0);
        put(K);   check("R7 disarmed after SE1", 1'b0);
        put(J);   check("R7 idle", 1'b0);
        put(K);   check("R7 rearmed", 1'b1);

        // R3 / R4 / R5: strict mode gap sweep
        strict = 1'b1;
        for (int n = 0; n <= LIMIT + 4; n++) begin
            put(J); check("R4 idle", 1'b0);
            for (int i = 0; i < n; i++) begin
                put(SE0); check("R4 SE0 alone", 1'b0);
            end
            put(K);
            if (n == 0) check("R3 J to K", 1'b1);
            else check((n < LIMIT) ? "R4 short gap" : "R5 long gap", (n < LIMIT));
            put(K); check("R8 held K", 1'b0);
        end
        // R5: after abort, J rearms
        put(J); check("R5 idle", 1'b0);
        for (int i = 0; i < LIMIT; i++) put(SE0);
        check("R5 abort", 1'b0);
        put(K); check("R5 K after abort", 1'b0);
        put(J); check("R5 idle", 1'b0);
        put(K); check("R5 rearm", 1'b1);

        // R6: short gap ending in J
        put(J); put(SE0); put(SE0); put(SE0);
        check("R6 gap", 1'b0);
        put(J); check("R6 back to J", 1'b0);
        put(K); check("R6 armed K", 1'b1);

        // R7: SE1 inside a strict gap
        put(J); put(SE0); put(SE0);
        put(SE1); check("R7 SE1 in gap", 1'b0);
        put(K);   check("R7 disarmed", 1'b0);
        put(J);   check("R7 idle", 1'b0);
        put(K);   check("R7 rearmed strict", 1'b1);

        // R9: mode change during a gap and before SE0
        put(J);   check("R9 idle", 1'b0);
        put(SE0); check("R9 strict SE0", 1'b0);
        strict = 1'b0;
        put(SE0); check("R9 default in gap", 1'b1);
        put(J);   check("R9 idle", 1'b0);
        strict = 1'b1;
        put(SE0); check("R9 strict again", 1'b0);
        put(K);   check("R9 strict K", 1'b1);

        // R8: long hold of K yields one pulse
        put(J); put(K); check("R8 first", 1'b1);
        for (int i = 0; i < 20; i++) begin
            put(K); check("R8 hold", 1'b0);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule